// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA descriptor engine of an Ethernet MAC. Received frame bytes arrive on a byte stream that marks the first and last byte of each frame. The engine walks a ring of 8-byte descriptors in memory through a single-word memory port. It stores each frame into the buffers those descriptors point to, and then hands every filled descriptor back to software with a status word and an ownership flag.

Software sets up the ring and programs the queue base address. It then raises the receive enable. A frame longer than one buffer spills into the following descriptors. Only the descriptor that takes the final bytes is marked as the frame end, and only that descriptor reports the frame length. If the engine meets a descriptor that software has not yet released, it drops the rest of that frame and raises a sticky overrun flag.

The memory port returns read data one cycle after the request and accepts every request. The stream is held back with a ready signal while the engine is busy with descriptor or data-word traffic.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After reset the block issues no memory request and the overrun flag is low.
- R2: Descriptor word 0 (at the descriptor address) holds the buffer address in bits 31:2, the wrap flag in bit 1 and the ownership flag in bit 0; word 1 (address + 4) holds status. The engine only fills a descriptor whose bit 0 is clear. Afterwards it rewrites word 0 with the same address and wrap flag and with bit 0 set.
- R3: Byte n of a buffer is stored at buffer address + n, in byte lane n mod 4 of a 32-bit little-endian word. A partial final word is written with only its filled lanes enabled.
- R4: After a descriptor whose wrap flag is set, the next descriptor used is the one at the queue base address; otherwise it is the one 8 bytes further on.
- R5: The status word has bit 14 set on the first buffer of a frame and bit 15 set on the last one. Bits 13:0 carry the total frame length on the last buffer and are zero on every other buffer. Bits 31:16 are zero.
- R6: Each buffer holds BUF_UNITS x 64 bytes (1536 by default). A longer frame continues in the next descriptor. A frame that exactly fills a buffer uses one descriptor only.
- R7: A descriptor's status word is written in the cycle just before its word 0 is written.
- R8: If the descriptor needed for a frame has bit 0 set when it is fetched, the rest of the frame is accepted and discarded with no memory write. The overrun flag then rises and stays high until reset. The next frame then retries that same descriptor.
- R9: While the receive enable is low between frames, stream bytes are accepted and discarded, and the ring position returns to the queue base. The first frame after enabling uses the descriptor at the queue base.
- R10: Stream bytes that arrive between frames without the first-byte marker are discarded and consume no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| q_base | input | 32 | Queue base address of the descriptor ring (8-byte aligned) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Stream byte accepted when high together with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| overrun | output | 1 | Sticky flag: a frame met a descriptor still owned by software |

## Verification
Every byte handshake, and every request on the memory port (a descriptor fetch, a data word, a status word, an ownership word), completes at a clock edge. The bench drives inputs at the falling edge and reads in_ready only after they settle, so each accepted byte is known exactly. After the last byte of a frame is accepted, the final data word, the status word and the ownership word land in the next three cycles. A descriptor fetch that finds bit 0 set raises overrun two cycles after the fetch. The bench therefore waits ten idle cycles after each frame before it inspects memory and the overrun flag. A monitor on the memory port checks the status-then-ownership order at each falling edge, where the port outputs are stable.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;
  localparam int LEN_W    = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FWAIT,
    ST_DROP,
    ST_FILL,
    ST_WDATA,
    ST_STAT,
    ST_OWN
  } rxr_state_e;

  // Status word for one descriptor.
  function automatic logic [31:0] rxr_status(input logic first,
                                             input logic last,
                                             input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = 32'd0;
    w[SOF_BIT] = first;
    w[EOF_BIT] = last;
    if (last) w[LEN_W-1:0] = len;
    return w;
  endfunction

  // Word 0 handed back to software: address and wrap kept, ownership set.
  function automatic logic [31:0] rxr_own(input logic [31:0] buf_base,
                                          input logic wrap);
    return {buf_base[31:2], wrap, 1'b1};
  endfunction

  // Address of the descriptor that follows the current one.
  function automatic logic [31:0] rxr_next(input logic [31:0] ptr,
                                           input logic wrap,
                                           input logic [31:0] base);
    return wrap ? base : ptr + 32'd8;
  endfunction

  // Word-aligned offset of the byte just stored (count is bytes stored).
  function automatic logic [31:0] rxr_word_off(input logic [31:0] count);
    logic [31:0] m1;
    m1 = count - 32'd1;
    return {m1[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_base,
  input  logic [31:0] q_base,
  input  logic        advance,
  input  logic        wrap,
  output logic [31:0] ptr
);
  import rxr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= 32'd0;
    else if (load_base)  ptr <= q_base;
    else if (advance)    ptr <= rxr_next(ptr, wrap, q_base);
  end

  // R4
  wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wrap && !load_base) |=> (ptr == $past(q_base)));

  // R4
  step_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wrap && !load_base) |=> (ptr == $past(ptr) + 32'd8));

endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [1:0]  lane,
  input  logic [7:0]  byte_in,
  input  logic        clear,
  output logic [31:0] word,
  output logic [3:0]  be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= 32'd0;
      be   <= 4'd0;
    end else if (clear) begin
      word <= 32'd0;
      be   <= 4'd0;
    end else if (push) begin
      word[lane*8 +: 8] <= byte_in;
      be[lane]          <= 1'b1;
    end
  end

  // R3
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (be == 4'h0) || (be == 4'h1) || (be == 4'h3) || (be == 4'h7) || (be == 4'hF));

  // R3
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> (be[lane] == 1'b0));

endmodule

// File: rtl/rx_desc_ring_writer.sv
module rx_desc_ring_writer #(
  parameter int BUF_UNITS  = 24,
  parameter int UNIT_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic [31:0] q_base,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_first,
  input  logic        in_last,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata,
  output logic        overrun
);
  import rxr_pkg::*;

  localparam int BUF_BYTES = BUF_UNITS * UNIT_BYTES;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

  rxr_state_e        st;
  logic [31:0]       buf_base;
  logic              wrap_q;
  logic [CNT_W-1:0]  buf_cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [LEN_W-1:0]  frame_len;
  logic              first_q;
  logic              last_q;
  logic              overrun_q;
  logic [31:0]       ptr;
  logic [31:0]       pk_word;
  logic [3:0]        pk_be;
  logic [31:0]       data_addr;

  // Named internal events.
  logic evt_accept;
  logic evt_fetch;
  logic evt_data_wr;
  logic evt_stat_wr;
  logic evt_own_wr;
  logic evt_owned_hit;
  logic fill_done;
  logic load_base;

  assign cnt_nxt       = buf_cnt + 1'b1;
  assign evt_accept    = in_valid && in_ready;
  assign evt_fetch     = (st == ST_FETCH);
  assign evt_data_wr   = (st == ST_WDATA);
  assign evt_stat_wr   = (st == ST_STAT);
  assign evt_own_wr    = (st == ST_OWN);
  assign evt_owned_hit = (st == ST_FWAIT) && mem_rdata[OWN_BIT];
  assign fill_done     = (buf_cnt[1:0] == 2'd3) || in_last || (cnt_nxt == CNT_FULL);
  assign load_base     = (st == ST_IDLE) && !rx_en;
  assign data_addr     = buf_base + rxr_word_off(32'(buf_cnt));
  assign overrun       = overrun_q;

  always_comb begin
    case (st)
      ST_IDLE:         in_ready = !(rx_en && in_valid && in_first);
      ST_DROP, ST_FILL: in_ready = 1'b1;
      default:         in_ready = 1'b0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    mem_be    = 4'hF;
    case (st)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr;
      end
      ST_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = data_addr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + 32'd4;
        mem_wdata = rxr_status(first_q, last_q, frame_len);
      end
      ST_OWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = rxr_own(buf_base, wrap_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      buf_base  <= 32'd0;
      wrap_q    <= 1'b0;
      buf_cnt   <= '0;
      frame_len <= '0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rx_en && in_valid && in_first) begin
            st        <= ST_FETCH;
            first_q   <= 1'b1;
            last_q    <= 1'b0;
            frame_len <= '0;
          end
        end
        ST_FETCH: st <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rdata[OWN_BIT]) begin
            overrun_q <= 1'b1;
            st        <= ST_DROP;
          end else begin
            buf_base <= {mem_rdata[31:2], 2'b00};
            wrap_q   <= mem_rdata[WRAP_BIT];
            buf_cnt  <= '0;
            st       <= ST_FILL;
          end
        end
        ST_DROP: begin
          if (evt_accept && in_last) st <= ST_IDLE;
        end
        ST_FILL: begin
          if (evt_accept) begin
            buf_cnt   <= cnt_nxt;
            frame_len <= frame_len + 1'b1;
            last_q    <= in_last;
            if (fill_done) st <= ST_WDATA;
          end
        end
        ST_WDATA: st <= (last_q || buf_cnt == CNT_FULL) ? ST_STAT : ST_FILL;
        ST_STAT:  st <= ST_OWN;
        ST_OWN: begin
          first_q <= 1'b0;
          st      <= last_q ? ST_IDLE : ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  rxr_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_base (load_base),
    .q_base    (q_base),
    .advance   (evt_own_wr),
    .wrap      (wrap_q),
    .ptr       (ptr)
  );

  rxr_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (evt_accept && (st == ST_FILL)),
    .lane    (buf_cnt[1:0]),
    .byte_in (in_data),
    .clear   (evt_data_wr),
    .word    (pk_word),
    .be      (pk_be)
  );

  // R7
  stat_then_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stat_wr |=> evt_own_wr);

  // R7
  own_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stat_wr |=> (mem_addr == $past(mem_addr) - 32'd4));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  owned_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_owned_hit |=> (overrun && !mem_req));

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= CNT_FULL);

  // R2
  fetch_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fetch |-> (mem_req && !mem_we && !in_ready));

endmodule

// File: tb/sim_rx_desc_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_desc_ring_writer;

  localparam int BUFB  = 64;
  localparam int RING  = 4;
  localparam logic [31:0] QB = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic [31:0] q_base = QB;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_first = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = 32'd0;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int ring_idx = 0;
  logic [31:0] mem [0:4095];
  logic [7:0]  fbytes [0:511];
  logic        prev_stat_wr = 1'b0;
  logic [31:0] prev_addr = 32'd0;

  always #2.5 clk = ~clk;

  rx_desc_ring_writer #(.BUF_UNITS(1), .UNIT_BYTES(64)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .q_base(q_base),
    .in_valid(in_valid), .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .overrun(overrun)
  );

  // Memory model: read data one cycle after request.
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[13:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ownership-word monitor (R7): the write just before must be the status word.
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_addr >= QB && mem_addr < QB + 8*RING
        && mem_addr[2] == 1'b0)
      chk(prev_stat_wr && prev_addr == mem_addr + 32'd4, "R7 status before ownership",
          prev_addr, mem_addr + 32'd4);
    prev_stat_wr = rst_n && mem_req && mem_we && mem_addr[2];
    prev_addr    = mem_addr;
  end

  function automatic logic [31:0] desc_addr(input int i);
    return QB + 32'(i * 8);
  endfunction

  function automatic logic [31:0] buf_addr(input int i);
    return 32'h1000 + 32'(i * 256);
  endfunction

  function automatic logic [31:0] exp_status(input bit first, input bit last, input int len);
    logic [31:0] s;
    s = last ? (32'h8000 + 32'(len)) : 32'h0;
    if (first) s = s + 32'h4000;
    return s;
  endfunction

  function automatic logic [7:0] get_byte(input logic [31:0] a);
    return mem[a[13:2]][a[1:0]*8 +: 8];
  endfunction

  task automatic init_ring();
    for (int i = 0; i < RING; i++) begin
      mem[desc_addr(i) >> 2]       = buf_addr(i) | ((i == RING-1) ? 32'h2 : 32'h0);
      mem[(desc_addr(i) >> 2) + 1] = 32'h0;
    end
  endtask

  task automatic make_bytes(input int len);
    for (int i = 0; i < len; i++) fbytes[i] = 8'($urandom);
  endtask

  task automatic send(input int len, input bit framed, input int gap_pct);
    for (int i = 0; i < len; i++) begin
      if (int'($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fbytes[i];
      in_first = framed && (i == 0);
      in_last  = framed && (i == len - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_frame(input int len);
    int nb;
    nb = (len + BUFB - 1) / BUFB;
    for (int k = 0; k < nb; k++) begin
      int idx, cnt, bad;
      logic [31:0] w0, w1, e0;
      idx = (ring_idx + k) % RING;
      w0 = mem[desc_addr(idx) >> 2];
      w1 = mem[(desc_addr(idx) >> 2) + 1];
      e0 = buf_addr(idx) | ((idx == RING-1) ? 32'h2 : 32'h0) | 32'h1;
      chk(w0 == e0, "R2 R4 word0", w0, e0);
      chk(w1 == exp_status(k == 0, k == nb-1, len), "R5 status", w1,
          exp_status(k == 0, k == nb-1, len));
      cnt = (k == nb-1) ? (len - k*BUFB) : BUFB;
      bad = 0;
      for (int b = 0; b < cnt; b++)
        if (get_byte(buf_addr(idx) + 32'(b)) != fbytes[k*BUFB + b]) bad++;
      chk(bad == 0, "R3 R6 buffer data", 32'(bad), 32'd0);
    end
    ring_idx = (ring_idx + nb) % RING;
    if (nb < RING)
      chk(mem[desc_addr(ring_idx) >> 2][0] == 1'b0, "R6 no extra descriptor",
          mem[desc_addr(ring_idx) >> 2], buf_addr(ring_idx));
    init_ring();
  endtask

  task automatic frame(input int len, input int gap_pct);
    make_bytes(len);
    send(len, 1'b1, gap_pct);
    check_frame(len);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int owned_cnt;
    void'($urandom(32'd7));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    init_ring();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0, "R1 no request after reset", 32'(mem_req), 32'd0);
    chk(overrun == 1'b0, "R1 overrun low after reset", 32'(overrun), 32'd0);
    rx_en = 1'b1;
    @(negedge clk);

    // Directed: short frame, exact-fill frame, multi-buffer frame across wrap.
    frame(10, 0);
    frame(BUFB, 0);
    frame(150, 10);
    frame(1, 0);
    frame(BUFB + 1, 30);

    // R10: stray bytes between frames
    make_bytes(5);
    send(5, 1'b0, 0);
    owned_cnt = 0;
    for (int i = 0; i < RING; i++) owned_cnt += int'(mem[desc_addr(i) >> 2][0]);
    chk(owned_cnt == 0, "R10 stray bytes consume nothing", 32'(owned_cnt), 32'd0);
    frame(20, 0);

    // Random frames
    for (int n = 0; n < 25; n++) frame(1 + int'($urandom % 250), 20);

    // R8: next descriptor still owned by software, frame spills into it
    chk(overrun == 1'b0, "R8 no overrun yet", 32'(overrun), 32'd0);
    begin
      int nxt;
      logic [31:0] held;
      nxt = (ring_idx + 1) % RING;
      held = mem[desc_addr(nxt) >> 2] | 32'h1;
      mem[desc_addr(nxt) >> 2] = held;
      make_bytes(150);
      send(150, 1'b1, 0);
      chk(mem[(desc_addr(ring_idx) >> 2) + 1] == 32'h4000, "R8 R5 partial status",
          mem[(desc_addr(ring_idx) >> 2) + 1], 32'h4000);
      chk(mem[desc_addr(ring_idx) >> 2][0] == 1'b1, "R8 first buffer handed back",
          mem[desc_addr(ring_idx) >> 2], 32'h1);
      chk(mem[desc_addr(nxt) >> 2] == held, "R8 owned word0 untouched",
          mem[desc_addr(nxt) >> 2], held);
      chk(mem[(desc_addr(nxt) >> 2) + 1] == 32'h0, "R8 owned status untouched",
          mem[(desc_addr(nxt) >> 2) + 1], 32'h0);
      chk(overrun == 1'b1, "R8 overrun set", 32'(overrun), 32'd1);
      init_ring();
      ring_idx = nxt;
      frame(20, 0);
      chk(overrun == 1'b1, "R8 overrun sticky", 32'(overrun), 32'd1);
    end

    // Ensure ring position is not at the base before the enable test
    if (ring_idx == 0) frame(10, 0);

    // R9: disabled receive discards, then restart at queue base
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    make_bytes(30);
    send(30, 1'b1, 0);
    owned_cnt = 0;
    for (int i = 0; i < RING; i++) owned_cnt += int'(mem[desc_addr(i) >> 2][0]);
    chk(owned_cnt == 0, "R9 disabled frame discarded", 32'(owned_cnt), 32'd0);
    chk(mem_req == 1'b0, "R9 no memory traffic when disabled", 32'(mem_req), 32'd0);
    rx_en = 1'b1;
    ring_idx = 0;
    @(negedge clk);
    frame(12, 0);
    frame(70, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule